// File: doc/BRIEF.md
# Accumulator Micro-Operation Unit

This unit executes the first group of operate-class micro-instructions of a small word-oriented processor. It works on a 12-bit accumulator and a 1-bit link. The instruction's operate field, the current accumulator and the current link go in. One clock later the unit returns the new accumulator, the new link, and four flags. The flags tell the register-file and hazard logic whether each of the two registers was read or written by the instruction.

Several micro-operation bits may be set in one instruction, and they always take effect in the same fixed sequence. First come the clears, then the complements, then the increment, and last the rotate or half-swap step. The increment and the rotates treat the link and the accumulator as a single 13-bit value. The link is the most significant bit of that value. An instruction whose group-select bit shows a different operate group is not executed: the unit raises no result for it and keeps its previous outputs.

Top module: `acc_microop_unit`

## Requirements
- R1: An accepted instruction (in_valid high, op_field bit 8 low) produces out_valid high exactly one clock later, with its results on acc_out, link_out and the flags. With no accepted instruction, out_valid is low in the next cycle.
- R2: When op_field bit 8 (mask 0400) is 1, the instruction is not executed: out_valid is low in the next cycle, and acc_out, link_out and all flags keep their previous values.
- R3: Bit 7 (0200) clears the accumulator and bit 6 (0100) clears the link. Both act before every other step.
- R4: Bit 5 (0040) inverts the accumulator and bit 4 (0020) inverts the link. Both act after the clears, so bits 7 and 5 together give 7777 octal.
- R5: Bit 0 (0001) adds one to the 13-bit value {link, accumulator}, after the complements. A carry out of the accumulator therefore toggles the link.
- R6: Bit 3 (0010) rotates {link, accumulator} right by one place and bit 2 (0004) rotates it left by one place, as a 13-bit ring. The link is the top bit of the ring. This step acts after the increment.
- R7: Bit 1 (0002) with neither rotate bit set exchanges the upper and lower 6-bit halves of the accumulator and leaves the link unchanged.
- R8: Bit 1 together with exactly one rotate bit rotates the 13-bit ring by two places in that rotate's direction.
- R9: With bits 3 and 2 both set, the rotate/swap step leaves the value unchanged and rot_conflict is 1. In every other case rot_conflict is 0.
- R10: acc_rd is the OR of bits 5, 3, 2, 1 and 0. link_rd is the OR of bits 4, 3, 2 and 0. acc_wr is the OR of bits 7, 5, 3, 2, 1 and 0. link_wr is the OR of bits 6, 4, 3, 2 and 0.
- R11: After synchronous reset, out_valid, acc_out, link_out, all four flags and rot_conflict are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| op_field | input | 9 | Operate field; bit 8 is the group select |
| acc_in | input | 12 | Current accumulator |
| link_in | input | 1 | Current link |
| out_valid | output | 1 | Result registered from the previous cycle |
| acc_out | output | 12 | New accumulator |
| link_out | output | 1 | New link |
| acc_rd | output | 1 | Instruction reads the accumulator |
| link_rd | output | 1 | Instruction reads the link |
| acc_wr | output | 1 | Instruction writes the accumulator |
| link_wr | output | 1 | Instruction writes the link |
| rot_conflict | output | 1 | Both rotate directions were requested |

## Verification
Some properties are checked on every cycle:
- the one-cycle result timing;
- that a foreign-group instruction is rejected;
- that a register not flagged as written returns its input value unchanged;
- that a pure clear yields zero;
- that a read flag always comes with the matching write flag.

Other behaviour can only be shown by the bench scenarios. These are the ordering of the stages, carry propagation into the link, ring rotation by one and by two places, the half-swap, and the value left by conflicting rotates. The bench checks them by sweeping all 256 micro-operation combinations over both link values and a set of accumulator patterns, and comparing each result with an arithmetic model.

// File: rtl/acc_uop_pkg.sv
package acc_uop_pkg;

  // Decoded micro-operation controls, one bit per operation.
  typedef struct packed {
    logic clr_acc;
    logic clr_link;
    logic cpl_acc;
    logic cpl_link;
    logic rot_r;
    logic rot_l;
    logic swap;
    logic inc;
  } uop_ctrl_t;

  // Bit positions inside the operate field.
  localparam int BIT_CLR_ACC  = 7;
  localparam int BIT_CLR_LINK = 6;
  localparam int BIT_CPL_ACC  = 5;
  localparam int BIT_CPL_LINK = 4;
  localparam int BIT_ROT_R    = 3;
  localparam int BIT_ROT_L    = 2;
  localparam int BIT_SWAP     = 1;
  localparam int BIT_INC      = 0;

endpackage

// File: rtl/acc_uop_decode.sv
module acc_uop_decode
  import acc_uop_pkg::*;
#(
  parameter int OP_W = 9
) (
  input  logic [OP_W-1:0] op,
  output uop_ctrl_t       ctrl,
  output logic            group_hit,
  output logic            acc_rd,
  output logic            link_rd,
  output logic            acc_wr,
  output logic            link_wr
);

  localparam int GROUP_BIT = OP_W - 1;

  always_comb begin
    ctrl.clr_acc  = op[BIT_CLR_ACC];
    ctrl.clr_link = op[BIT_CLR_LINK];
    ctrl.cpl_acc  = op[BIT_CPL_ACC];
    ctrl.cpl_link = op[BIT_CPL_LINK];
    ctrl.rot_r    = op[BIT_ROT_R];
    ctrl.rot_l    = op[BIT_ROT_L];
    ctrl.swap     = op[BIT_SWAP];
    ctrl.inc      = op[BIT_INC];
  end

  // This group is selected by a zero in the top bit of the field.
  assign group_hit = ~op[GROUP_BIT];

  // Register usage flags for the hazard logic.
  assign acc_rd  = ctrl.cpl_acc | ctrl.rot_r | ctrl.rot_l | ctrl.swap | ctrl.inc;
  assign link_rd = ctrl.cpl_link | ctrl.rot_r | ctrl.rot_l | ctrl.inc;
  assign acc_wr  = ctrl.clr_acc | acc_rd;
  assign link_wr = ctrl.clr_link | link_rd;

endmodule

// File: rtl/acc_uop_arith.sv
module acc_uop_arith
  import acc_uop_pkg::*;
#(
  parameter int ACC_W = 12
) (
  input  uop_ctrl_t        ctrl,
  input  logic [ACC_W-1:0] acc,
  input  logic             link,
  output logic [ACC_W:0]   ring
);

  localparam int RING_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_c;
  logic             link_c;

  // Stage 1: clears. Stage 2: complements. Stage 3: increment of {link,acc}.
  always_comb begin
    acc_c  = ctrl.clr_acc  ? '0   : acc;
    link_c = ctrl.clr_link ? 1'b0 : link;
    if (ctrl.cpl_acc)  acc_c  = ~acc_c;
    if (ctrl.cpl_link) link_c = ~link_c;
    ring = {link_c, acc_c};
    if (ctrl.inc) ring = ring + RING_W'(1);
  end

endmodule

// File: rtl/acc_uop_shift.sv
module acc_uop_shift
  import acc_uop_pkg::*;
#(
  parameter int ACC_W   = 12,
  parameter int MAX_ROT = 2
) (
  input  uop_ctrl_t      ctrl,
  input  logic [ACC_W:0] ring_in,
  output logic [ACC_W:0] ring_out,
  output logic           conflict
);

  localparam int RING_W = ACC_W + 1;
  localparam int HALF   = ACC_W / 2;

  // Candidate rotations by 1..MAX_ROT places in each direction.
  logic [RING_W-1:0] rot_right [1:MAX_ROT];
  logic [RING_W-1:0] rot_left  [1:MAX_ROT];

  for (genvar k = 1; k <= MAX_ROT; k++) begin : g_rot
    assign rot_right[k] = {ring_in[k-1:0], ring_in[RING_W-1:k]};
    assign rot_left[k]  = {ring_in[RING_W-1-k:0], ring_in[RING_W-1:RING_W-k]};
  end

  logic [RING_W-1:0] swapped;
  assign swapped = {ring_in[ACC_W], ring_in[HALF-1:0], ring_in[ACC_W-1:HALF]};

  assign conflict = ctrl.rot_r & ctrl.rot_l;

  // Stage 4: a single rotate, a double rotate (rotate plus swap), or a swap.
  always_comb begin
    ring_out = ring_in;
    if (!conflict) begin
      if (ctrl.rot_r)      ring_out = ctrl.swap ? rot_right[2] : rot_right[1];
      else if (ctrl.rot_l) ring_out = ctrl.swap ? rot_left[2]  : rot_left[1];
      else if (ctrl.swap)  ring_out = swapped;
    end
  end

endmodule

// File: rtl/acc_microop_unit.sv
module acc_microop_unit
  import acc_uop_pkg::*;
#(
  parameter int ACC_W = 12,
  parameter int OP_W  = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  op_field,
  input  logic [ACC_W-1:0] acc_in,
  input  logic             link_in,
  output logic             out_valid,
  output logic [ACC_W-1:0] acc_out,
  output logic             link_out,
  output logic             acc_rd,
  output logic             link_rd,
  output logic             acc_wr,
  output logic             link_wr,
  output logic             rot_conflict
);

  uop_ctrl_t      ctrl;
  logic           group_hit;
  logic           d_acc_rd, d_link_rd, d_acc_wr, d_link_wr;
  logic [ACC_W:0] ring_mid, ring_fin;
  logic           d_conflict;
  logic           accept;

  acc_uop_decode #(.OP_W(OP_W)) u_decode (
    .op        (op_field),
    .ctrl      (ctrl),
    .group_hit (group_hit),
    .acc_rd    (d_acc_rd),
    .link_rd   (d_link_rd),
    .acc_wr    (d_acc_wr),
    .link_wr   (d_link_wr)
  );

  acc_uop_arith #(.ACC_W(ACC_W)) u_arith (
    .ctrl (ctrl),
    .acc  (acc_in),
    .link (link_in),
    .ring (ring_mid)
  );

  acc_uop_shift #(.ACC_W(ACC_W), .MAX_ROT(2)) u_shift (
    .ctrl     (ctrl),
    .ring_in  (ring_mid),
    .ring_out (ring_fin),
    .conflict (d_conflict)
  );

  assign accept = in_valid & group_hit;

  // Registered output stage; holds its contents when nothing is accepted.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      acc_out      <= '0;
      link_out     <= 1'b0;
      acc_rd       <= 1'b0;
      link_rd      <= 1'b0;
      acc_wr       <= 1'b0;
      link_wr      <= 1'b0;
      rot_conflict <= 1'b0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        acc_out      <= ring_fin[ACC_W-1:0];
        link_out     <= ring_fin[ACC_W];
        acc_rd       <= d_acc_rd;
        link_rd      <= d_link_rd;
        acc_wr       <= d_acc_wr;
        link_wr      <= d_link_wr;
        rot_conflict <= d_conflict;
      end
    end
  end

  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_field[OP_W-1]) |=> out_valid); // R1

  AST_FOREIGN_GROUP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_field[OP_W-1]) |=> (!out_valid && $stable(acc_out) && $stable(link_out))); // R2

  AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_field == OP_W'(9'o200)) |=> (acc_out == '0)); // R3

  AST_ACC_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_field[OP_W-1] && op_field[7:0] == 8'o020) |=> (acc_out == $past(acc_in) && !acc_wr)); // R10

  AST_LINK_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !link_wr) |-> (link_out == $past(link_in))); // R10

  AST_READ_WRITES: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((!acc_rd || acc_wr) && (!link_rd || link_wr))); // R10

endmodule

// File: tb/acc_microop_unit_bench.sv
module acc_microop_unit_bench;

  localparam int ACC_W = 12;
  localparam int OP_W  = 9;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid;
  logic [OP_W-1:0]  op_field;
  logic [ACC_W-1:0] acc_in;
  logic             link_in;
  logic             out_valid;
  logic [ACC_W-1:0] acc_out;
  logic             link_out;
  logic             acc_rd, link_rd, acc_wr, link_wr, rot_conflict;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  acc_microop_unit #(.ACC_W(ACC_W), .OP_W(OP_W)) u_acc_microop_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_field(op_field),
    .acc_in(acc_in), .link_in(link_in), .out_valid(out_valid),
    .acc_out(acc_out), .link_out(link_out), .acc_rd(acc_rd),
    .link_rd(link_rd), .acc_wr(acc_wr), .link_wr(link_wr),
    .rot_conflict(rot_conflict)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0o expected %0o", tag, act, exp);
    end
  endtask

  // Arithmetic model of the requirements.
  function automatic logic [12:0] model(input logic [7:0] b, input logic [11:0] a, input logic l);
    logic [12:0] v;
    int n;
    if (b[7]) a = 12'o0;
    if (b[6]) l = 1'b0;
    if (b[5]) a = ~a;
    if (b[4]) l = ~l;
    v = {l, a};
    if (b[0]) v = v + 13'd1;
    n = b[1] ? 2 : 1;
    if (b[3] && b[2]) begin
      v = v;
    end else if (b[3]) begin
      for (int i = 0; i < n; i++) v = {v[0], v[12:1]};
    end else if (b[2]) begin
      for (int i = 0; i < n; i++) v = {v[11:0], v[12]};
    end else if (b[1]) begin
      v = {v[12], v[5:0], v[11:6]};
    end
    return v;
  endfunction

  function automatic string tag_of(input logic [7:0] b);
    if (b[3] && b[2])        return "R9";
    if (b[1] && (b[3]|b[2])) return "R8";
    if (b[3] || b[2])        return "R6";
    if (b[1])                return "R7";
    if (b[0])                return "R5";
    if (b[5] || b[4])        return "R4";
    return "R3";
  endfunction

  task automatic apply(input logic [8:0] op, input logic [11:0] a, input logic l);
    @(negedge clk);
    in_valid = 1'b1; op_field = op; acc_in = a; link_in = l;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_one(input logic [7:0] b, input logic [11:0] a, input logic l);
    logic [12:0] e;
    string t;
    apply({1'b0, b}, a, l);
    e = model(b, a, l);
    t = tag_of(b);
    check({t, " acc"}, 32'(acc_out), 32'(e[11:0]));
    check({t, " link"}, 32'(link_out), 32'(e[12]));
    check("R1 valid", 32'(out_valid), 32'd1);
    check("R9 conflict", 32'(rot_conflict), 32'(b[3] & b[2]));
    check("R10 acc_rd", 32'(acc_rd), 32'(b[5] | b[3] | b[2] | b[1] | b[0]));
    check("R10 link_rd", 32'(link_rd), 32'(b[4] | b[3] | b[2] | b[0]));
    check("R10 acc_wr", 32'(acc_wr), 32'(b[7] | b[5] | b[3] | b[2] | b[1] | b[0]));
    check("R10 link_wr", 32'(link_wr), 32'(b[6] | b[4] | b[3] | b[2] | b[0]));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] pats [9];
    pats = '{12'o0000, 12'o7777, 12'o0001, 12'o4000, 12'o3777,
             12'o0077, 12'o7700, 12'o5252, 12'o1234};
    rst = 1'b1; in_valid = 1'b0; op_field = '0; acc_in = '0; link_in = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 valid", 32'(out_valid), 0);
    check("R11 acc", 32'(acc_out), 0);
    check("R11 link", 32'(link_out), 0);
    check("R11 flags", 32'({acc_rd, link_rd, acc_wr, link_wr, rot_conflict}), 0);
    rst = 1'b0;

    // Directed corner cases
    run_one(8'o240, 12'o1234, 1'b0);             // R4 clear then complement -> 7777
    check("R4 cla+cma", 32'(acc_out), 32'o7777);
    run_one(8'o001, 12'o7777, 1'b0);             // R5 carry toggles link
    check("R5 carry acc", 32'(acc_out), 0);
    check("R5 carry link", 32'(link_out), 1);
    run_one(8'o010, 12'o0001, 1'b0);             // R6 right: bit0 into link
    check("R6 rar link", 32'(link_out), 1);
    run_one(8'o004, 12'o0000, 1'b1);             // R6 left: link into bit0
    check("R6 ral acc", 32'(acc_out), 1);
    run_one(8'o002, 12'o1234, 1'b1);             // R7 half swap
    check("R7 swap", 32'(acc_out), 32'o3412);
    run_one(8'o012, 12'o0001, 1'b0);             // R8 double right
    check("R8 rtr", 32'({link_out, acc_out}), 32'o10000 >> 1);
    run_one(8'o014, 12'o1234, 1'b1);             // R9 both rotates
    check("R9 unchanged", 32'({link_out, acc_out}), 32'o11234);

    // R1 no accepted instruction -> no valid
    @(negedge clk);
    check("R1 idle", 32'(out_valid), 0);

    // R2 foreign group: outputs hold
    run_one(8'o001, 12'o0100, 1'b0);
    apply(9'o401, 12'o5555, 1'b1);
    check("R2 valid", 32'(out_valid), 0);
    check("R2 acc hold", 32'(acc_out), 32'o0101);
    check("R2 link hold", 32'(link_out), 0);
    check("R2 flag hold", 32'({acc_rd, acc_wr}), 32'b11);

    // Exhaustive sweep of the micro-operation bits
    for (int b = 0; b < 256; b++)
      for (int p = 0; p < 9; p++)
        for (int l = 0; l < 2; l++)
          run_one(8'(b), pats[p], 1'(l));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule